// File: doc/BRIEF.md
# Lossy Constant-Latency Hit Lane Multiplexer

This block gathers the hit flags of a row of strip channels and packs them onto a small, fixed set of output lanes once per bunch crossing. A crossing enters every clock. A pipeline of stages works through the channels in ascending order, with each stage covering one contiguous group of channels. Each stage carries a running lane index and a fill state along with the partly built output word. When a channel has a hit, a steering element enables one lane, writes the channel number and its row address into that lane, and advances the index.

Once every lane is taken, the crossing's fill state moves from `FILL_OPEN` to `FILL_FULL`. It makes this transition when a hit claims the last lane. No transition leads back within the crossing. Every later hit in that crossing is discarded, and the crossing's overflow flag is set. Each crossing starts in `FILL_OPEN` with index zero when it enters the first stage. The output word appears a fixed number of clocks later, and that number does not depend on how many channels fired.

With the default settings there are 31 channels, 8 lanes and 11 channels per stage, which gives 3 stages. At a 25 ns crossing clock this is a 75 ns latency. Each lane also carries a 4-bit row address. The `ROW_EN` parameter selects the variant without row addresses.

Top module: `hit_lane_mux`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, lane_vld, lane_ch, lane_row and overflow are all zero.
- R2: The output word for a crossing sampled on hit_in at a rising edge appears after exactly NSTAGE = ceil(NCHAN/GRP) further rising edges (3 by default). This latency is the same for every occupancy.
- R3: Hits are given lanes in ascending channel order. The k-th lowest hit channel goes to lane k, and lane_ch field k (bits k*5 +: 5) holds that channel number.
- R4: A lane without a hit has lane_vld bit 0 and all-zero channel and row fields.
- R5: The number of set lane_vld bits equals the smaller of the crossing's hit count and NLANE (8). The set bits always form a contiguous run starting at lane 0.
- R6: overflow is 1 exactly when the crossing had more than NLANE hits, and it is aligned with that crossing's word. In that case the lanes hold the NLANE lowest hit channels and all higher hits are dropped.
- R7: With ROW_EN = 1, lane_row field k (bits k*4 +: 4) equals the row_in field of the channel placed on lane k. Channel c's row_in field is bits c*4 +: 4.
- R8: A new crossing is accepted every clock. Consecutive crossings are independent: the lane index and fill state never carry over from one crossing to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_in | input | NCHAN (31) | Hit flags of the current crossing, one per channel |
| row_in | input | NCHAN*ROW_W (124) | Row address per channel, channel c at bits c*ROW_W +: ROW_W |
| lane_vld | output | NLANE (8) | Lane occupied flags |
| lane_ch | output | NLANE*CH_W (40) | Channel number per lane |
| lane_row | output | NLANE*ROW_W (32) | Row address per lane |
| overflow | output | 1 | Crossing had more hits than lanes |

## Verification
Some properties are checked on every cycle. The checker keeps its own delayed hit count per crossing. Against it, each cycle it checks that the lane count and the overflow flag agree with the count from NSTAGE clocks earlier. It also checks that the occupied lanes form a run from lane 0, that channel numbers rise from lane to lane, and that idle lanes are zero. Other behaviour can only be seen through the bench's scenarios. These are: which channel and row land on which lane, that the index restarts for each crossing, and the overflow cases that fall at a stage boundary or inside one stage. The bench compares whole output words with a reference model to show these.

// File: rtl/hmux_pkg.sv
package hmux_pkg;

    // Fill state of one crossing as it walks the pipeline.
    typedef enum logic {
        FILL_OPEN = 1'b0,   // lanes still free
        FILL_FULL = 1'b1    // every lane taken, further hits are dropped
    } fill_e;

endpackage

// File: rtl/hmux_lane_steer.sv
module hmux_lane_steer
    import hmux_pkg::*;
#(
    parameter int NLANE = 8,
    parameter int IDX_W = 3
) (
    input  logic             hit,
    input  logic [IDX_W-1:0] idx_in,
    input  fill_e            fill_in,
    output logic [IDX_W-1:0] idx_out,
    output fill_e            fill_out,
    output logic [NLANE-1:0] lane_en,
    output logic             drop
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NLANE - 1);

    // Enabled demultiplexer plus index adder for one channel.
    always_comb begin
        idx_out  = idx_in;
        fill_out = fill_in;
        lane_en  = '0;
        drop     = 1'b0;
        unique case (fill_in)
            FILL_OPEN: begin
                if (hit) begin
                    lane_en[idx_in] = 1'b1;
                    idx_out         = idx_in + IDX_W'(1);
                    if (idx_in == LAST_IDX) begin
                        fill_out = FILL_FULL;
                    end
                end
            end
            FILL_FULL: begin
                drop = hit;
            end
        endcase
    end

endmodule

// File: rtl/hmux_stage.sv
module hmux_stage
    import hmux_pkg::*;
#(
    parameter int NCHAN = 31,
    parameter int NLANE = 8,
    parameter int GRP   = 11,
    parameter int STAGE = 0,
    parameter int ROW_W = 4,
    parameter int CH_W  = 5,
    parameter int IDX_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCHAN-1:0]       in_hits,
    input  logic [NCHAN*ROW_W-1:0] in_rows,
    input  logic [IDX_W-1:0]       in_idx,
    input  fill_e                  in_fill,
    input  logic                   in_ovf,
    input  logic [NLANE-1:0]       in_vld,
    input  logic [NLANE*CH_W-1:0]  in_ch,
    input  logic [NLANE*ROW_W-1:0] in_row,
    output logic [NCHAN-1:0]       out_hits,
    output logic [NCHAN*ROW_W-1:0] out_rows,
    output logic [IDX_W-1:0]       out_idx,
    output fill_e                  out_fill,
    output logic                   out_ovf,
    output logic [NLANE-1:0]       out_vld,
    output logic [NLANE*CH_W-1:0]  out_ch,
    output logic [NLANE*ROW_W-1:0] out_row
);

    localparam int BASE = STAGE * GRP;

    logic [IDX_W-1:0] idx_c  [0:GRP];
    fill_e            fill_c [0:GRP];
    logic [NLANE-1:0] en_c   [0:GRP-1];
    logic [GRP-1:0]   drop_c;

    assign idx_c[0]  = in_idx;
    assign fill_c[0] = in_fill;

    // Chain of steering elements, one per channel of this group.
    for (genvar c = 0; c < GRP; c++) begin : g_chan
        if (BASE + c < NCHAN) begin : g_live
            hmux_lane_steer #(
                .NLANE (NLANE),
                .IDX_W (IDX_W)
            ) u_steer (
                .hit      (in_hits[BASE + c]),
                .idx_in   (idx_c[c]),
                .fill_in  (fill_c[c]),
                .idx_out  (idx_c[c+1]),
                .fill_out (fill_c[c+1]),
                .lane_en  (en_c[c]),
                .drop     (drop_c[c])
            );
        end else begin : g_pad
            assign idx_c[c+1]  = idx_c[c];
            assign fill_c[c+1] = fill_c[c];
            assign en_c[c]     = '0;
            assign drop_c[c]   = 1'b0;
        end
    end

    logic [NLANE-1:0]       nxt_vld;
    logic [NLANE*CH_W-1:0]  nxt_ch;
    logic [NLANE*ROW_W-1:0] nxt_row;
    logic                   nxt_ovf;

    // Output process: merge the enabled lanes into the word in flight.
    always_comb begin
        nxt_vld = in_vld;
        nxt_ch  = in_ch;
        nxt_row = in_row;
        for (int c = 0; c < GRP; c++) begin
            for (int l = 0; l < NLANE; l++) begin
                if ((BASE + c) < NCHAN && en_c[c][l]) begin
                    nxt_vld[l]                   = 1'b1;
                    nxt_ch[l*CH_W +: CH_W]       = CH_W'(BASE + c);
                    nxt_row[l*ROW_W +: ROW_W]    = in_rows[(BASE + c)*ROW_W +: ROW_W];
                end
            end
        end
        nxt_ovf = in_ovf | (|drop_c);
    end

    // State register of this pipeline stage.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_hits <= '0;
            out_rows <= '0;
            out_idx  <= '0;
            out_fill <= FILL_OPEN;
            out_ovf  <= 1'b0;
            out_vld  <= '0;
            out_ch   <= '0;
            out_row  <= '0;
        end else begin
            out_hits <= in_hits;
            out_rows <= in_rows;
            out_idx  <= idx_c[GRP];
            out_fill <= fill_c[GRP];
            out_ovf  <= nxt_ovf;
            out_vld  <= nxt_vld;
            out_ch   <= nxt_ch;
            out_row  <= nxt_row;
        end
    end

endmodule

// File: rtl/hit_lane_mux.sv
module hit_lane_mux
    import hmux_pkg::*;
#(
    parameter int NCHAN  = 31,
    parameter int NLANE  = 8,
    parameter int GRP    = 11,
    parameter int ROW_W  = 4,
    parameter int ROW_EN = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NCHAN-1:0]                 hit_in,
    input  logic [NCHAN*ROW_W-1:0]           row_in,
    output logic [NLANE-1:0]                 lane_vld,
    output logic [NLANE*$clog2(NCHAN)-1:0]   lane_ch,
    output logic [NLANE*ROW_W-1:0]           lane_row,
    output logic                             overflow
);

    localparam int CH_W   = $clog2(NCHAN);
    localparam int IDX_W  = $clog2(NLANE);
    localparam int NSTAGE = (NCHAN + GRP - 1) / GRP;

    logic [NCHAN-1:0]       hits_l [0:NSTAGE];
    logic [NCHAN*ROW_W-1:0] rows_l [0:NSTAGE];
    logic [IDX_W-1:0]       idx_l  [0:NSTAGE];
    fill_e                  fill_l [0:NSTAGE];
    logic                   ovf_l  [0:NSTAGE];
    logic [NLANE-1:0]       vld_l  [0:NSTAGE];
    logic [NLANE*CH_W-1:0]  ch_l   [0:NSTAGE];
    logic [NLANE*ROW_W-1:0] row_l  [0:NSTAGE];

    // Every crossing enters with an empty word and index zero.
    assign hits_l[0] = hit_in;
    assign idx_l[0]  = '0;
    assign fill_l[0] = FILL_OPEN;
    assign ovf_l[0]  = 1'b0;
    assign vld_l[0]  = '0;
    assign ch_l[0]   = '0;
    assign row_l[0]  = '0;

    if (ROW_EN != 0) begin : g_rows
        assign rows_l[0] = row_in;
    end else begin : g_norows
        logic row_in_unused;
        assign row_in_unused = ^row_in;
        assign rows_l[0]     = '0;
    end

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        hmux_stage #(
            .NCHAN (NCHAN),
            .NLANE (NLANE),
            .GRP   (GRP),
            .STAGE (s),
            .ROW_W (ROW_W),
            .CH_W  (CH_W),
            .IDX_W (IDX_W)
        ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_hits  (hits_l[s]),
            .in_rows  (rows_l[s]),
            .in_idx   (idx_l[s]),
            .in_fill  (fill_l[s]),
            .in_ovf   (ovf_l[s]),
            .in_vld   (vld_l[s]),
            .in_ch    (ch_l[s]),
            .in_row   (row_l[s]),
            .out_hits (hits_l[s+1]),
            .out_rows (rows_l[s+1]),
            .out_idx  (idx_l[s+1]),
            .out_fill (fill_l[s+1]),
            .out_ovf  (ovf_l[s+1]),
            .out_vld  (vld_l[s+1]),
            .out_ch   (ch_l[s+1]),
            .out_row  (row_l[s+1])
        );
    end

    assign lane_vld = vld_l[NSTAGE];
    assign lane_ch  = ch_l[NSTAGE];
    assign lane_row = row_l[NSTAGE];
    assign overflow = ovf_l[NSTAGE];

    // Pipeline tail fields with no consumer past the last stage.
    logic tail_unused;
    assign tail_unused = ^{hits_l[NSTAGE], rows_l[NSTAGE], idx_l[NSTAGE], fill_l[NSTAGE]};

endmodule

// File: rtl/hmux_checker.sv
module hmux_checker #(
    parameter int NCHAN  = 31,
    parameter int NLANE  = 8,
    parameter int ROW_W  = 4,
    parameter int NSTAGE = 3
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NCHAN-1:0]               hit_in,
    input logic [NLANE-1:0]               lane_vld,
    input logic [NLANE*$clog2(NCHAN)-1:0] lane_ch,
    input logic [NLANE*ROW_W-1:0]         lane_row,
    input logic                           overflow
);

    localparam int CH_W  = $clog2(NCHAN);
    localparam int CNT_W = $clog2(NCHAN + 1);

    logic [CNT_W-1:0] cnt_pipe [0:NSTAGE-1];
    logic [CNT_W-1:0] cnt_d;
    int               exp_lanes;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSTAGE; i++) cnt_pipe[i] <= '0;
        end else begin
            cnt_pipe[0] <= CNT_W'($countones(hit_in));
            for (int i = 1; i < NSTAGE; i++) cnt_pipe[i] <= cnt_pipe[i-1];
        end
    end

    assign cnt_d     = cnt_pipe[NSTAGE-1];
    assign exp_lanes = (int'(cnt_d) > NLANE) ? NLANE : int'(cnt_d);

    // R5 and R2: lane count matches the crossing from NSTAGE clocks before
    a_r5_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lane_vld) == exp_lanes);

    // R6: overflow marks exactly the crossings with too many hits
    a_r6_overflow_match: assert property (@(posedge clk) disable iff (!rst_n)
        overflow == (int'(cnt_d) > NLANE));

    // R5: occupied lanes are contiguous from lane 0
    a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_vld & (lane_vld + NLANE'(1))) == '0);

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        // R4: idle lane has zero fields
        a_r4_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !lane_vld[l] |-> (lane_ch[l*CH_W +: CH_W] == '0 && lane_row[l*ROW_W +: ROW_W] == '0));
        if (l > 0) begin : g_order
            // R3: channel numbers rise with the lane number
            a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
                lane_vld[l] |-> (lane_ch[l*CH_W +: CH_W] > lane_ch[(l-1)*CH_W +: CH_W]));
        end
    end

endmodule

bind hit_lane_mux hmux_checker #(
    .NCHAN  (NCHAN),
    .NLANE  (NLANE),
    .ROW_W  (ROW_W),
    .NSTAGE (NSTAGE)
) u_hmux_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_in   (hit_in),
    .lane_vld (lane_vld),
    .lane_ch  (lane_ch),
    .lane_row (lane_row),
    .overflow (overflow)
);

// File: tb/hit_lane_mux_test.sv
module hit_lane_mux_test;

    localparam int NCHAN = 31;
    localparam int NLANE = 8;
    localparam int GRP   = 11;
    localparam int ROW_W = 4;
    localparam int CH_W  = 5;
    localparam int LAT   = 3;
    localparam int MAXC  = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCHAN-1:0]       hit_in = '0;
    logic [NCHAN*ROW_W-1:0] row_in = '0;
    logic [NLANE-1:0]       lane_vld;
    logic [NLANE*CH_W-1:0]  lane_ch;
    logic [NLANE*ROW_W-1:0] lane_row;
    logic                   overflow;

    always #10 clk = ~clk;

    hit_lane_mux #(
        .NCHAN (NCHAN), .NLANE (NLANE), .GRP (GRP), .ROW_W (ROW_W), .ROW_EN (1)
    ) uut (
        .clk (clk), .rst_n (rst_n), .hit_in (hit_in), .row_in (row_in),
        .lane_vld (lane_vld), .lane_ch (lane_ch), .lane_row (lane_row), .overflow (overflow)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [NCHAN-1:0]       h_hist [0:MAXC-1];
    logic [NCHAN*ROW_W-1:0] r_hist [0:MAXC-1];
    string                  t_hist [0:MAXC-1];

    function automatic void model(input logic [NCHAN-1:0] h, input logic [NCHAN*ROW_W-1:0] r,
                                  output logic [NLANE-1:0] v, output logic [NLANE*CH_W-1:0] ch,
                                  output logic [NLANE*ROW_W-1:0] rw, output logic ovf);
        int k = 0;
        v = '0; ch = '0; rw = '0;
        for (int c = 0; c < NCHAN; c++) begin
            if (h[c]) begin
                if (k < NLANE) begin
                    v[k] = 1'b1;
                    ch[k*CH_W +: CH_W] = CH_W'(c);
                    rw[k*ROW_W +: ROW_W] = r[c*ROW_W +: ROW_W];
                end
                k++;
            end
        end
        ovf = (k > NLANE);
    endfunction

    function automatic logic [NCHAN*ROW_W-1:0] rnd_rows();
        logic [NCHAN*ROW_W-1:0] rr;
        for (int i = 0; i < NCHAN; i++) rr[i*ROW_W +: ROW_W] = ROW_W'($urandom);
        return rr;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [NCHAN-1:0]       h;
        logic [NCHAN*ROW_W-1:0] r;
        string                  tg;
        logic [NLANE-1:0]       ev;
        logic [NLANE*CH_W-1:0]  ec;
        logic [NLANE*ROW_W-1:0] er;
        logic                   eo;
        if (cyc >= LAT) begin
            h = h_hist[cyc-LAT]; r = r_hist[cyc-LAT]; tg = t_hist[cyc-LAT];
        end else begin
            h = '0; r = '0; tg = "R2 pipeline fill";
        end
        model(h, r, ev, ec, er, eo);
        check(lane_vld == ev, "R5", {tg, " lane valid"}, 64'(lane_vld), 64'(ev));
        check(lane_ch == ec, "R3 R4", {tg, " lane channel"}, 64'(lane_ch), 64'(ec));
        check(lane_row == er, "R7", {tg, " lane row"}, 64'(lane_row), 64'(er));
        check(overflow == eo, "R6", {tg, " overflow"}, 64'(overflow), 64'(eo));
    endtask

    task automatic drive(input logic [NCHAN-1:0] h, input logic [NCHAN*ROW_W-1:0] r, input string tg);
        @(negedge clk);
        compare();
        hit_in = h;
        row_in = r;
        h_hist[cyc] = h; r_hist[cyc] = r; t_hist[cyc] = tg;
        cyc++;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        void'($urandom(32'd7007));
        repeat (3) @(negedge clk);
        check(lane_vld == '0 && overflow == 1'b0, "R1", "during reset", 64'({lane_vld, overflow}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(lane_vld == '0 && lane_ch == '0 && lane_row == '0 && overflow == 1'b0,
              "R1", "after reset", 64'(lane_ch), 64'd0);

        drive('0, rnd_rows(), "R4 empty crossing");
        drive(31'h0000_0020, rnd_rows(), "R2 lone hit latency");
        drive('0, rnd_rows(), "R2 quiet after hit");
        drive('0, rnd_rows(), "R2 quiet");
        drive(31'h0000_0C00, rnd_rows(), "R3 stage boundary carry");
        drive(31'h4442_1211, rnd_rows(), "R5 exactly eight hits");
        drive(31'h4442_9211, rnd_rows(), "R6 ninth hit dropped");
        drive('1, rnd_rows(), "R6 all channels");
        drive(31'h4000_0000, rnd_rows(), "R8 last channel after full");
        drive('1, rnd_rows(), "R8 full again");
        drive(31'h7FC0_0000, rnd_rows(), "R6 overflow inside last stage");
        drive(31'h4000_00FF, rnd_rows(), "R5 last channel dropped");
        drive(31'h0000_0001, rnd_rows(), "R8 index restarts");

        for (int n = 0; n < 600; n++) begin
            logic [NCHAN-1:0] h;
            int pct;
            case ($urandom % 4)
                0: pct = 3;
                1: pct = 20;
                2: pct = 45;
                default: pct = 80;
            endcase
            for (int c = 0; c < NCHAN; c++) h[c] = (($urandom % 100) < pct);
            drive(h, rnd_rows(), "R8 random crossing");
        end

        for (int n = 0; n <= LAT; n++) drive('0, '0, "R2 flush");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule